// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit picks the address of the next instruction for a 32-bit RISC core whose instructions are all one word long. It looks at the opcode and function fields of the current instruction, together with the two source register values. Ordinary instructions step to the following word. Equal and not-equal branches move by a signed word displacement taken from the 16-bit immediate, measured from the following word. Absolute jumps and calls keep the top four bits of the following word's address and fill the rest from the 26-bit target field. The register jump goes to the address held in the first source register.

A call also asks for the return address to be written to the link register. The unit drives a write enable, a fixed register index and the return value for that write, and it raises a taken flag whenever the flow leaves the sequential path. All results are registered, so they appear one clock after the instruction fields are presented. Reset clears the next PC, the taken flag, the link enable and the link value to zero. If the link index is configured as register 0, which always reads zero, the link write is never enabled.

Top module: `npc_unit`

## Requirements
- R1: Any instruction other than the five control-flow forms sets the next PC to PC+4 (modulo 2^32), with taken low, link enable low and link value zero. This covers opcode 000000 when funct is not 001000.
- R2: Opcode 000100 (branch-if-equal) gives PC+4 plus the sign-extended immediate shifted left by 2, with taken high, when the two register values are equal; otherwise it gives PC+4 with taken low. It never writes the link register.
- R3: Opcode 000101 (branch-if-not-equal) takes the same displacement target with taken high when the register values differ, and gives PC+4 with taken low when they are equal.
- R4: The immediate is treated as two's complement, so 0xFFFF moves back one word from PC+4 and 0x8000 moves back 0x20000 bytes.
- R5: Opcode 000010 (jump) gives {PC+4 bits 31:28, target, 2'b00} with taken high and link enable low. The upper bits come from PC+4 and not from PC, which matters when PC+4 crosses into the next 256 MB region.
- R6: Opcode 000011 (call) gives the same target as R5 with taken high and link enable high. The link index is 31 and the link value is PC+4.
- R7: Opcode 000000 with funct 001000 (register jump) sets the next PC to the first register value, with taken high and link enable low.
- R8: Every output changes only at a rising clock edge and reflects the inputs present just before that edge. While reset is low, the next PC, taken, link enable and link value all read zero.
- R9: Whenever the link enable is high, taken is high too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field of register-format instructions |
| imm_i | input | 16 | Immediate field, branch displacement in words |
| target_i | input | 26 | Jump target field, in words |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| npc_o | output | 32 | Registered next program counter |
| taken_o | output | 1 | Registered flag: flow leaves the sequential path |
| link_we_o | output | 1 | Registered link register write enable |
| link_idx_o | output | 5 | Link register index (constant 31) |
| link_val_o | output | 32 | Registered return address, zero when no link write |

## Verification
Every result of this unit is due exactly one rising edge after its instruction fields and register values are driven. The bench therefore changes inputs on a falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. One scenario also reads the outputs just after new inputs arrive and before the edge, to show that they still hold the previous result. The properties use the same single-edge relation: they compare each output with the values that the inputs and the target arithmetic had one edge earlier.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned OP_W    = 6;
  localparam int unsigned FUNCT_W = 6;

  localparam logic [OP_W-1:0]    OPC_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0]    OPC_JUMP    = 6'b000010;
  localparam logic [OP_W-1:0]    OPC_CALL    = 6'b000011;
  localparam logic [OP_W-1:0]    OPC_BR_EQ   = 6'b000100;
  localparam logic [OP_W-1:0]    OPC_BR_NE   = 6'b000101;
  localparam logic [FUNCT_W-1:0] FN_REG_JUMP = 6'b001000;

  typedef enum logic [2:0] {
    FLOW_SEQ   = 3'd0,
    FLOW_BR_EQ = 3'd1,
    FLOW_BR_NE = 3'd2,
    FLOW_JUMP  = 3'd3,
    FLOW_CALL  = 3'd4,
    FLOW_REGJ  = 3'd5
  } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output flow_e              flow_o
);

  always_comb begin
    flow_o = FLOW_SEQ;
    case (opcode_i)
      OPC_BR_EQ: flow_o = FLOW_BR_EQ;
      OPC_BR_NE: flow_o = FLOW_BR_NE;
      OPC_JUMP:  flow_o = FLOW_JUMP;
      OPC_CALL:  flow_o = FLOW_CALL;
      OPC_SPECIAL: begin
        if (funct_i == FN_REG_JUMP) flow_o = FLOW_REGJ;
      end
      default: flow_o = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned TGT_W = 26
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [PC_W-1:0]  rs_val_i,
  input  logic [PC_W-1:0]  rt_val_i,
  output logic [PC_W-1:0]  seq_pc_o,
  output logic [PC_W-1:0]  branch_pc_o,
  output logic [PC_W-1:0]  jump_pc_o,
  output logic             regs_eq_o
);

  localparam int unsigned BYTE_SH  = 2;
  localparam int unsigned WORD_B   = 1 << BYTE_SH;
  localparam int unsigned EXT_W    = PC_W - IMM_W - BYTE_SH;
  localparam int unsigned REGION_W = PC_W - TGT_W - BYTE_SH;

  function automatic logic [PC_W-1:0] step_word(input logic [PC_W-1:0] pc);
    return pc + PC_W'(WORD_B);
  endfunction

  function automatic logic [PC_W-1:0] disp_bytes(input logic [IMM_W-1:0] imm);
    return {{EXT_W{imm[IMM_W-1]}}, imm, {BYTE_SH{1'b0}}};
  endfunction

  function automatic logic [PC_W-1:0] region_jump(input logic [REGION_W-1:0] region,
                                                  input logic [TGT_W-1:0]    tgt);
    return {region, tgt, {BYTE_SH{1'b0}}};
  endfunction

  logic [PC_W-1:0]     seq_pc;
  logic [REGION_W-1:0] region_bits;

  assign seq_pc      = step_word(pc_i);
  assign region_bits = seq_pc[PC_W-1 -: REGION_W];

  assign seq_pc_o    = seq_pc;
  assign branch_pc_o = seq_pc + disp_bytes(imm_i);
  assign jump_pc_o   = region_jump(region_bits, target_i);
  assign regs_eq_o   = (rs_val_i == rt_val_i);

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned LINK_IDX  = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  flow_e                flow_i,
  input  logic                 regs_eq_i,
  input  logic [PC_W-1:0]      seq_pc_i,
  input  logic [PC_W-1:0]      branch_pc_i,
  input  logic [PC_W-1:0]      jump_pc_i,
  input  logic [PC_W-1:0]      reg_pc_i,
  output logic [PC_W-1:0]      npc_o,
  output logic                 taken_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [PC_W-1:0]      link_val_o
);

  logic [PC_W-1:0] npc_d;
  logic            taken_d;
  logic            call_d;
  logic            link_d;
  logic [PC_W-1:0] link_val_d;

  always_comb begin
    npc_d   = seq_pc_i;
    taken_d = 1'b0;
    call_d  = 1'b0;
    case (flow_i)
      FLOW_BR_EQ: begin
        taken_d = regs_eq_i;
        npc_d   = regs_eq_i ? branch_pc_i : seq_pc_i;
      end
      FLOW_BR_NE: begin
        taken_d = !regs_eq_i;
        npc_d   = regs_eq_i ? seq_pc_i : branch_pc_i;
      end
      FLOW_JUMP: begin
        taken_d = 1'b1;
        npc_d   = jump_pc_i;
      end
      FLOW_CALL: begin
        taken_d = 1'b1;
        call_d  = 1'b1;
        npc_d   = jump_pc_i;
      end
      FLOW_REGJ: begin
        taken_d = 1'b1;
        npc_d   = reg_pc_i;
      end
      default: begin
        taken_d = 1'b0;
      end
    endcase
  end

  generate
    if (LINK_IDX == 0) begin : gen_link_off
      assign link_d = 1'b0;
      logic unused_call;
      assign unused_call = call_d;
    end else begin : gen_link_on
      assign link_d = call_d;
    end
  endgenerate

  assign link_val_d = link_d ? seq_pc_i : '0;
  assign link_idx_o = REG_IDX_W'(LINK_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_o      <= '0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
    end else begin
      npc_o      <= npc_d;
      taken_o    <= taken_d;
      link_we_o  <= link_d;
      link_val_o <= link_val_d;
    end
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned IMM_W     = 16,
  parameter int unsigned TGT_W     = 26,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned LINK_IDX  = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [OP_W-1:0]      opcode_i,
  input  logic [FUNCT_W-1:0]   funct_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [TGT_W-1:0]     target_i,
  input  logic [PC_W-1:0]      rs_val_i,
  input  logic [PC_W-1:0]      rt_val_i,
  output logic [PC_W-1:0]      npc_o,
  output logic                 taken_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [PC_W-1:0]      link_val_o
);

  flow_e           flow_kind;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] branch_pc;
  logic [PC_W-1:0] jump_pc;
  logic            regs_eq;

  npc_decode u_decode (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .flow_o   (flow_kind)
  );

  npc_target #(
    .PC_W  (PC_W),
    .IMM_W (IMM_W),
    .TGT_W (TGT_W)
  ) u_target (
    .pc_i        (pc_i),
    .imm_i       (imm_i),
    .target_i    (target_i),
    .rs_val_i    (rs_val_i),
    .rt_val_i    (rt_val_i),
    .seq_pc_o    (seq_pc),
    .branch_pc_o (branch_pc),
    .jump_pc_o   (jump_pc),
    .regs_eq_o   (regs_eq)
  );

  npc_select #(
    .PC_W      (PC_W),
    .REG_IDX_W (REG_IDX_W),
    .LINK_IDX  (LINK_IDX)
  ) u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .flow_i      (flow_kind),
    .regs_eq_i   (regs_eq),
    .seq_pc_i    (seq_pc),
    .branch_pc_i (branch_pc),
    .jump_pc_i   (jump_pc),
    .reg_pc_i    (rs_val_i),
    .npc_o       (npc_o),
    .taken_o     (taken_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_val_o  (link_val_o)
  );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned TGT_W    = 26,
  parameter int unsigned LINK_IDX = 31
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc_i,
  input logic [PC_W-1:0] rs_val_i,
  input logic [PC_W-1:0] rt_val_i,
  input flow_e           flow_kind,
  input logic [PC_W-1:0] seq_pc,
  input logic [PC_W-1:0] branch_pc,
  input logic [PC_W-1:0] jump_pc,
  input logic [PC_W-1:0] npc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [PC_W-1:0] link_val_o
);

  localparam int unsigned REGION_W = PC_W - TGT_W - 2;

  a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_SEQ) |=>
      (npc_o == $past(pc_i) + PC_W'(4)) && !taken_o && !link_we_o && (link_val_o == '0));

  a_r2_equal_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_BR_EQ && rs_val_i == rt_val_i) |=>
      taken_o && (npc_o == $past(branch_pc)) && !link_we_o);

  a_r2_equal_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_BR_EQ && rs_val_i != rt_val_i) |=>
      !taken_o && (npc_o == $past(seq_pc)));

  a_r3_notequal: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_BR_NE) |=>
      (taken_o == ($past(rs_val_i) != $past(rt_val_i))) &&
      (npc_o == (taken_o ? $past(branch_pc) : $past(seq_pc))));

  a_r5_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_JUMP) |=>
      taken_o && !link_we_o &&
      (npc_o[PC_W-1 -: REGION_W] == $past(seq_pc[PC_W-1 -: REGION_W])) &&
      (npc_o[1:0] == 2'b00));

  a_r6_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_CALL && LINK_IDX != 0) |=>
      link_we_o && (link_val_o == $past(seq_pc)) && (npc_o == $past(jump_pc)));

  a_r7_register_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_kind == FLOW_REGJ) |=>
      taken_o && !link_we_o && (npc_o == $past(rs_val_i)));

  a_r9_link_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> taken_o);

endmodule

bind npc_unit npc_unit_chk #(
  .PC_W     (PC_W),
  .TGT_W    (TGT_W),
  .LINK_IDX (LINK_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_i       (pc_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .flow_kind  (flow_kind),
  .seq_pc     (seq_pc),
  .branch_pc  (branch_pc),
  .jump_pc    (jump_pc),
  .npc_o      (npc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [5:0]  opcode_i = '0;
  logic [5:0]  funct_i = '0;
  logic [15:0] imm_i = '0;
  logic [25:0] target_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] npc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_val_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .opcode_i(opcode_i), .funct_i(funct_i),
    .imm_i(imm_i), .target_i(target_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_val_o(link_val_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] e_npc, input logic e_tk,
                         input logic e_we, input logic [31:0] e_lv);
    chk(req, "npc",   npc_o, e_npc);
    chk(req, "taken", {31'd0, taken_o}, {31'd0, e_tk});
    chk(req, "link_we", {31'd0, link_we_o}, {31'd0, e_we});
    chk(req, "link_val", link_val_o, e_lv);
  endtask

  function automatic logic [31:0] br_dest(input logic [31:0] pc, input logic [15:0] imm);
    return pc + 32'd4 + (32'($signed(imm)) * 32'd4);
  endfunction

  function automatic logic [31:0] jp_dest(input logic [31:0] pc, input logic [25:0] tg);
    logic [31:0] nxt;
    nxt = pc + 32'd4;
    return {nxt[31:28], 28'(tg) << 2};
  endfunction

  task automatic step(input logic [31:0] pc, input logic [5:0] op, input logic [5:0] fn,
                      input logic [15:0] imm, input logic [25:0] tg,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    pc_i = pc; opcode_i = op; funct_i = fn; imm_i = imm; target_i = tg;
    rs_val_i = a; rt_val_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    pc_i = 32'h0040_0000; opcode_i = 6'b000011; target_i = 26'h123;
    repeat (2) @(negedge clk);
    chk_all("R8", 32'h0, 1'b0, 1'b0, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_sequential;
    step(32'h0040_0000, 6'b001000, 6'd0, 16'h1234, 26'h0, 32'h5, 32'h5);
    chk_all("R1", 32'h0040_0004, 1'b0, 1'b0, 32'h0);
    step(32'h0040_0100, 6'b000000, 6'b100000, 16'h0, 26'h0, 32'h9, 32'h9);
    chk_all("R1", 32'h0040_0104, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_wrap;
    step(32'hFFFF_FFFC, 6'b100011, 6'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    chk_all("R1", 32'h0000_0000, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_beq;
    step(32'h0000_1000, 6'b000100, 6'd0, 16'h0010, 26'h0, 32'h77, 32'h77);
    chk_all("R2", br_dest(32'h1000, 16'h0010), 1'b1, 1'b0, 32'h0);
    step(32'h0000_1000, 6'b000100, 6'd0, 16'h0010, 26'h0, 32'h77, 32'h78);
    chk_all("R2", 32'h0000_1004, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_bne;
    step(32'h0000_2000, 6'b000101, 6'd0, 16'h0003, 26'h0, 32'h1, 32'h2);
    chk_all("R3", br_dest(32'h2000, 16'h0003), 1'b1, 1'b0, 32'h0);
    step(32'h0000_2000, 6'b000101, 6'd0, 16'h0003, 26'h0, 32'hAB, 32'hAB);
    chk_all("R3", 32'h0000_2004, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_negative;
    step(32'h0000_3000, 6'b000100, 6'd0, 16'hFFFF, 26'h0, 32'h0, 32'h0);
    chk("R4", "npc back one word", npc_o, 32'h0000_3000);
    step(32'h0004_0000, 6'b000101, 6'd0, 16'h8000, 26'h0, 32'h0, 32'h1);
    chk("R4", "npc most negative", npc_o, 32'h0002_0004);
    chk("R4", "npc vs bench formula", npc_o, br_dest(32'h0004_0000, 16'h8000));
  endtask

  task automatic t_jump;
    step(32'h8000_0000, 6'b000010, 6'd0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0);
    chk_all("R5", 32'h8FFF_FFFC, 1'b1, 1'b0, 32'h0);
    step(32'h0FFF_FFFC, 6'b000010, 6'd0, 16'h0, 26'h000_0010, 32'h0, 32'h0);
    chk_all("R5", 32'h1000_0040, 1'b1, 1'b0, 32'h0);
    chk("R5", "npc vs bench formula", npc_o, jp_dest(32'h0FFF_FFFC, 26'h10));
  endtask

  task automatic t_call;
    step(32'h0040_0020, 6'b000011, 6'd0, 16'h0, 26'h000_0100, 32'h0, 32'h0);
    chk_all("R6", 32'h0000_0400, 1'b1, 1'b1, 32'h0040_0024);
    chk("R6", "link_idx", {27'd0, link_idx_o}, 32'd31);
    chk("R9", "taken with link", {31'd0, taken_o}, 32'd1);
  endtask

  task automatic t_regjump;
    step(32'h0040_0040, 6'b000000, 6'b001000, 16'h0, 26'h0, 32'hDEAD_BEE0, 32'h1);
    chk_all("R7", 32'hDEAD_BEE0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_latency;
    step(32'h0000_5000, 6'b000010, 6'd0, 16'h0, 26'h000_0200, 32'h0, 32'h0);
    chk("R8", "first result", npc_o, 32'h0000_0800);
    @(negedge clk);
    pc_i = 32'h0000_6000; opcode_i = 6'b001101;
    #1;
    chk("R8", "held before edge", npc_o, 32'h0000_0800);
    chk("R8", "taken held before edge", {31'd0, taken_o}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk_all("R8", 32'h0000_6004, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_wrap();
    t_beq();
    t_bne();
    t_negative();
    t_jump();
    t_call();
    t_regjump();
    t_latency();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule